// File: doc/BRIEF.md
# Compare-Match System Timer

This block is a free-running system counter, 56 bits wide by default, with a single compare channel. A simple 32-bit register bus reaches it. Reads are combinational, so every access finishes in one cycle. Software starts and stops the counter through a counter-frame control bit. It reads the count as two words, and the same count is also visible through a read-only mirror. To schedule an event, software loads a compare value and sets the compare enable. Once the enabled channel sees the count at or past the compare value, it latches a status bit. When the mask bit allows it, that status drives a level interrupt.

There is no write-one-to-clear acknowledge. Clearing the compare enable drops the status and the interrupt at the same clock edge. By default the counter advances once every three clock cycles. A strap input removes the divider so that the counter advances on every cycle. There is no snapshot latch on the count words. Software reading the high word, then the low word, then the high word again will see any carry between its reads and can retry.

Top module: `syscnt_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low. Registers: counter control 0x00000, count words, compare words and compare control 0x1002C.
- R2: With `nodiv_i` high, the counter rises by one on every clock edge at which counter control bit 0 (offset 0x00000) is 1.
- R3: With `nodiv_i` low, the counter rises by one on every third enabled edge. The divider phase restarts from zero while the counter is stopped, so the first step comes on the third enabled edge.
- R4: While counter control bit 0 is 0, the count holds its value.
- R5: The low 32 bits of the count read at 0x00008, and the upper bits read zero-extended at 0x0000C. The same words read at 0x20008 and 0x2000C. Writes to those mirror offsets have no effect.
- R6: The compare low word is at 0x10020 and the compare high word at 0x10024. The high word keeps only the implemented upper 24 bits, and bits above them read as zero.
- R7: In compare control (0x1002C), bit 0 is the enable, bit 1 is the mask and bit 2 is read-only status. With the enable at 1, status sets on the edge after the count first stands at or above the compare value. Status then stays set while the enable stays 1.
- R8: `irq_o` is high exactly when status, enable and mask bit 1 are all 1. Clearing the mask hides the interrupt without losing status.
- R9: A compare-control write with bit 0 = 0 clears status and drops `irq_o` at that same edge.
- R10: Compare writes made while the enable is 0 never set status. If the compare value is already reached when the enable is set to 1, status sets on the very next edge.
- R11: Unmapped offsets read as zero and ignore writes. A read returns data in the cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nodiv_i | input | 1 | Strap: 1 removes the divide-by-3 prescaler |
| bus_sel_i | input | 1 | Access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 18 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
A vector table drives the counting function under several strap settings and run lengths. Run lengths of 2 and 3 cycles at divide-by-3 separate a divider that steps on its third enabled edge from one that steps too early or too late. Equal run lengths with the strap on and off show whether the bypass really removes the divider. The compare channel is tried four ways: with a target the count reaches later, with a target already passed when the enable is set, with compare writes made while disabled, and with mask toggling while status is held. Together these tell apart the edge-triggered set, the sticky status, the gating by mask and the clear-through-enable path.

// File: rtl/syscnt_pkg.sv
package syscnt_pkg;

  localparam int BUS_AW = 18;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_RUN_CTL  = 18'h00000;
  localparam logic [BUS_AW-1:0] OFS_CNT_LO   = 18'h00008;
  localparam logic [BUS_AW-1:0] OFS_CNT_HI   = 18'h0000C;
  localparam logic [BUS_AW-1:0] OFS_CMP_LO   = 18'h10020;
  localparam logic [BUS_AW-1:0] OFS_CMP_HI   = 18'h10024;
  localparam logic [BUS_AW-1:0] OFS_CMP_CTL  = 18'h1002C;
  localparam logic [BUS_AW-1:0] OFS_MIR_LO   = 18'h20008;
  localparam logic [BUS_AW-1:0] OFS_MIR_HI   = 18'h2000C;

  // compare-control bit positions (software decodes these)
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int CTL_STAT_BIT = 2;

  // target reached: count at or above compare
  function automatic logic target_reached(input logic [63:0] cnt, input logic [63:0] cmp);
    return cnt >= cmp;
  endfunction

  // next count value given a tick
  function automatic logic [63:0] advance(input logic [63:0] cnt, input logic tick);
    return tick ? cnt + 64'd1 : cnt;
  endfunction

endpackage

// File: rtl/syscnt_tick.sv
module syscnt_tick #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic bypass_i,
  output logic tick_o
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase_q;

  assign tick_o = run_i && (bypass_i || (phase_q == PH_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n)                 phase_q <= '0;
    else if (!run_i || bypass_i) phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else                        phase_q <= phase_q + PH_W'(1);
  end

  // R3
  no_double_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !bypass_i) |=> !(tick_o && !bypass_i));

endmodule

// File: rtl/syscnt_counter.sv
module syscnt_counter #(
  parameter int CNT_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  import syscnt_pkg::*;

  logic [63:0] count_ext;
  logic [63:0] count_nxt;

  assign count_ext = 64'(count_o);
  assign count_nxt = advance(count_ext, tick_i);

  always_ff @(posedge clk) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= count_nxt[CNT_W-1:0];
  end

  // R4
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(count_o));

  // R2
  step_of_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (count_o == $past(count_o) + CNT_W'(1)));

endmodule

// File: rtl/syscnt_cmp.sv
module syscnt_cmp #(
  parameter int CNT_W = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic             wr_ctl_i,
  input  logic [31:0]      wdata_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             en_o,
  output logic             mask_o,
  output logic             stat_o,
  output logic             irq_o
);
  import syscnt_pkg::*;

  localparam int HI_W = CNT_W - 32;

  logic hit;
  logic dis_wr;

  assign hit    = target_reached(64'(count_i), 64'(cmp_o));
  assign dis_wr = wr_ctl_i && !wdata_i[CTL_EN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_o <= '0;
    end else begin
      if (wr_lo_i) cmp_o[31:0]       <= wdata_i;
      if (wr_hi_i) cmp_o[CNT_W-1:32] <= wdata_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o   <= 1'b0;
      mask_o <= 1'b0;
    end else if (wr_ctl_i) begin
      en_o   <= wdata_i[CTL_EN_BIT];
      mask_o <= wdata_i[CTL_MASK_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      stat_o <= 1'b0;
    else if (dis_wr) stat_o <= 1'b0;
    else if (en_o)   stat_o <= stat_o | hit;
    else             stat_o <= 1'b0;
  end

  assign irq_o = stat_o & en_o & mask_o;

  // R9
  stat_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> !stat_o);

  // R7
  stat_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && hit && !wr_ctl_i) |=> stat_o);

  // R7
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o && !dis_wr) |=> stat_o);

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_o |-> !irq_o);

endmodule

// File: rtl/syscnt_timer.sv
module syscnt_timer #(
  parameter int CNT_W = 56,
  parameter int DIV   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nodiv_i,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic [17:0] bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_o
);
  import syscnt_pkg::*;

  logic             run_q;
  logic             tick;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cmp;
  logic             cmp_en, cmp_mask, cmp_stat;
  logic             wr_run, wr_lo, wr_hi, wr_ctl;
  logic [63:0]      count_ext, cmp_ext;

  assign wr_run = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_RUN_CTL);
  assign wr_lo  = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_CMP_LO);
  assign wr_hi  = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_CMP_HI);
  assign wr_ctl = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_CMP_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (wr_run) run_q <= bus_wdata_i[0];
  end

  syscnt_tick #(.DIV(DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_q),
    .bypass_i (nodiv_i),
    .tick_o   (tick)
  );

  syscnt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .count_o (count)
  );

  syscnt_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_i  (count),
    .wr_lo_i  (wr_lo),
    .wr_hi_i  (wr_hi),
    .wr_ctl_i (wr_ctl),
    .wdata_i  (bus_wdata_i),
    .cmp_o    (cmp),
    .en_o     (cmp_en),
    .mask_o   (cmp_mask),
    .stat_o   (cmp_stat),
    .irq_o    (irq_o)
  );

  assign count_ext = 64'(count);
  assign cmp_ext   = 64'(cmp);

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      case (bus_addr_i)
        OFS_RUN_CTL:             bus_rdata_o = {31'd0, run_q};
        OFS_CNT_LO, OFS_MIR_LO:  bus_rdata_o = count_ext[31:0];
        OFS_CNT_HI, OFS_MIR_HI:  bus_rdata_o = count_ext[63:32];
        OFS_CMP_LO:              bus_rdata_o = cmp_ext[31:0];
        OFS_CMP_HI:              bus_rdata_o = cmp_ext[63:32];
        OFS_CMP_CTL:             bus_rdata_o = {29'd0, cmp_stat, cmp_mask, cmp_en};
        default:                 bus_rdata_o = '0;
      endcase
    end
  end

  // R11
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel_i |-> (bus_rdata_o == 32'd0));

  // R4
  stopped_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(count));

endmodule

// File: tb/test_syscnt_timer.sv
module test_syscnt_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nodiv = 1'b1;
  logic        sel = 1'b0, wr = 1'b0;
  logic [17:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] v, v2;

  always #10 clk = ~clk;

  syscnt_timer i_syscnt_timer (
    .clk(clk), .rst_n(rst_n), .nodiv_i(nodiv),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // {strap, enabled edges, expected count}
  localparam logic [39:0] VEC [6] = '{
    {8'd1, 16'd10, 16'd10},
    {8'd0, 16'd10, 16'd3},
    {8'd0, 16'd2,  16'd0},
    {8'd0, 16'd3,  16'd1},
    {8'd1, 16'd1,  16'd1},
    {8'd0, 16'd30, 16'd10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start at a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bwr(input logic [17:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic brd(input logic [17:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #2 d = rdata;
    #2 sel = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    brd(18'h00000, v); chk("R1 run ctl", v, 0);
    brd(18'h00008, v); chk("R1 count lo", v, 0);
    brd(18'h10020, v); chk("R1 cmp lo", v, 0);
    brd(18'h1002C, v); chk("R1 cmp ctl", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 / R3 counting vectors
    foreach (VEC[i]) begin
      nodiv = VEC[i][32];
      do_reset();
      bwr(18'h00000, 1);
      repeat (int'(VEC[i][31:16])) @(negedge clk);
      brd(18'h00008, v);
      chk(VEC[i][32] ? "R2 count" : "R3 count", v, {16'd0, VEC[i][15:0]});
    end

    // R7 / R8 compare event
    nodiv = 1'b1;
    do_reset();
    bwr(18'h10020, 20);
    bwr(18'h10024, 0);
    bwr(18'h1002C, 3);
    bwr(18'h00000, 1);
    repeat (20) @(negedge clk);
    chk("R7 before target", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R7 at target", {31'd0, irq}, 1);
    repeat (3) @(negedge clk);
    brd(18'h1002C, v); chk("R7 sticky", v, 32'h7);
    bwr(18'h1002C, 1);
    chk("R8 masked", {31'd0, irq}, 0);
    brd(18'h1002C, v); chk("R8 status kept", v, 32'h5);
    bwr(18'h1002C, 3);
    chk("R8 unmasked", {31'd0, irq}, 1);

    // R9 acknowledge through enable
    bwr(18'h1002C, 2);
    chk("R9 irq drop", {31'd0, irq}, 0);
    brd(18'h1002C, v); chk("R9 status clear", v, 32'h2);

    // R10 writes while disabled, then target already passed
    bwr(18'h10020, 0);
    repeat (4) @(negedge clk);
    brd(18'h1002C, v); chk("R10 disabled write", v, 32'h2);
    bwr(18'h1002C, 3);
    chk("R10 not same edge", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R10 next edge", {31'd0, irq}, 1);

    // R6 compare high width
    bwr(18'h10024, 32'hFFFF_FFFF);
    brd(18'h10024, v); chk("R6 cmp hi", v, 32'h00FF_FFFF);
    brd(18'h10020, v); chk("R6 cmp lo", v, 0);

    // R4 hold, R5 mirror
    bwr(18'h00000, 0);
    brd(18'h00008, v);
    repeat (5) @(negedge clk);
    brd(18'h00008, v2); chk("R4 hold", v2, v);
    brd(18'h20008, v2); chk("R5 mirror lo", v2, v);
    brd(18'h0000C, v2); chk("R5 count hi", v2, 0);
    brd(18'h2000C, v2); chk("R5 mirror hi", v2, 0);
    bwr(18'h20008, 32'hDEAD_BEEF);
    brd(18'h00008, v2); chk("R5 mirror write ignored", v2, v);

    // R11 unmapped
    bwr(18'h00004, 32'hFFFF_FFFF);
    brd(18'h00004, v); chk("R11 unmapped read", v, 0);
    brd(18'h00000, v); chk("R11 write ignored", v, 0);
    brd(18'h10028, v); chk("R11 gap read", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule